// File: doc/BRIEF.md
# ECC Error Transaction ID Logger

This block records which memory transaction hit the first single-bit (corrected) ECC error, so that software can later work out the failing address from it. It watches the stream of retire commands coming back from the memory data controller. Each command carries a 6-bit transaction identifier and a flag that marks a corrected single-bit error. On the first flagged retire, the identifier is latched and a valid bit is raised. Later errors leave the stored identifier alone until software releases it.

Software reaches the 8-bit log register through a simple configuration read/write port. The register answers at function 0, offset 80h, and its power-on value is 00h. Bit 6 is the capture flag and is cleared by writing 1 to it. Bits 5:0 hold the identifier and are read-only. Bit 7 is a general-purpose read/write bit.

The register is sticky: only the power-on reset clears it. A warm reset leaves its contents unchanged. While the warm reset is held, the block ignores retire and configuration traffic and drives zero on the read-data output.

Top module: `ecc_tid_logger`

## Requirements
- R1: After power-on reset (`por_n` low), the log register is 00h and `cfg_rdata` is 00h.
- R2: A read with `cfg_func`=0 and `cfg_offset`=80h puts the register value on `cfg_rdata` one clock later. A read at any other function or offset, and any cycle without a read, gives 00h.
- R3: A retire with `retire_valid`=1 and `retire_sbe`=1 while bit 6 is 0 sets bit 6 and loads `retire_tid` into bits 5:0 at the next clock edge.
- R4: A retire with `retire_sbe`=0, or an asserted `retire_sbe` without `retire_valid`, changes nothing.
- R5: While bit 6 is 1, later error retires leave bits 6:0 unchanged, unless a clear arrives in the same cycle.
- R6: A write to the register with data bit 6 = 1 clears bits 6:0 to 0.
- R7: A write with data bit 6 = 0 leaves bits 6:0 unchanged. Data bits 5:0 are always ignored.
- R8: Bit 7 takes data bit 7 on every write to the register, and its value has no effect on capture.
- R9: If a capturing retire and a clearing write fall in the same cycle, the capture wins: bit 6 ends at 1 and bits 5:0 hold the new identifier.
- R10: While `warm_rst_n` is low, the register keeps its value, `cfg_rdata` is 00h one clock later, and retires and writes are ignored.
- R11: Writes to any function or offset other than function 0, offset 80h leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low; the log register survives it |
| retire_valid | input | 1 | A retire command is present this cycle |
| retire_sbe | input | 1 | The retire reports a corrected single-bit ECC error |
| retire_tid | input | 6 | Transaction identifier of the retire |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_func | input | 3 | Function number of the access |
| cfg_offset | input | 8 | Register offset of the access |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data, valid the cycle after a read |

## Verification
The capture path is tried with clean retires, error flags that arrive without a valid strobe, a first flagged retire, and further flagged retires behind it. Together these separate "triggers only on a valid error retire" from "overwrites on every error." Writes are tried with bit 6 set and clear, with junk in the read-only bits, with bit 7 toggled, and at a neighbouring offset. This distinguishes a proper write-1-to-clear from a plain overwrite and from a loose address decode. A same-cycle clear and capture shows which one has priority. Finally, traffic driven during a warm reset, followed by a second power-on reset, tells a sticky register apart from an ordinary one.

// File: rtl/elt_pkg.sv
package elt_pkg;
  parameter int TID_W  = 6;
  parameter int FUNC_W = 3;
  parameter int OFF_W  = 8;
  localparam int REG_W    = TID_W + 2;
  localparam int FLAG_BIT = TID_W;
  localparam int SPARE_BIT = TID_W + 1;

  typedef struct packed {
    logic             spare;
    logic             flag;
    logic [TID_W-1:0] tid;
  } log_t;

  // capture fires on a flagged retire when the slot is free or being freed now
  function automatic logic capture_ok(logic valid, logic sbe, logic flag, logic clr);
    return valid & sbe & (~flag | clr);
  endfunction

  // next register value; capture is applied last so it wins over clear
  function automatic log_t log_next(log_t cur, logic cap, logic clr, logic wr,
                                    logic spare_in, logic [TID_W-1:0] tid_in);
    log_t n;
    n = cur;
    if (wr) n.spare = spare_in;
    if (clr) begin
      n.flag = 1'b0;
      n.tid  = '0;
    end
    if (cap) begin
      n.flag = 1'b1;
      n.tid  = tid_in;
    end
    return n;
  endfunction
endpackage

// File: rtl/elt_cfg_decode.sv
module elt_cfg_decode #(
  parameter int FUNC_W = 3,
  parameter int OFF_W  = 8,
  parameter logic [FUNC_W-1:0] MY_FUNC = '0,
  parameter logic [OFF_W-1:0]  MY_OFF  = 8'h80
) (
  input  logic              active,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [FUNC_W-1:0] cfg_func,
  input  logic [OFF_W-1:0]  cfg_offset,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic addr_match;
  assign addr_match = (cfg_func == MY_FUNC) && (cfg_offset == MY_OFF);
  assign wr_hit = active & cfg_wr & addr_match;
  assign rd_hit = active & cfg_rd & addr_match;
endmodule

// File: rtl/elt_capture.sv
module elt_capture
  import elt_pkg::*;
(
  input  logic             active,
  input  logic             retire_valid,
  input  logic             retire_sbe,
  input  logic [TID_W-1:0] retire_tid,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  input  log_t             cur,
  output logic             cap_evt,
  output logic             clr_evt,
  output log_t             nxt
);
  assign clr_evt = wr_hit & wdata[FLAG_BIT];
  assign cap_evt = active & capture_ok(retire_valid, retire_sbe, cur.flag, clr_evt);
  assign nxt     = log_next(cur, cap_evt, clr_evt, wr_hit, wdata[SPARE_BIT], retire_tid);
endmodule

// File: rtl/elt_log_store.sv
module elt_log_store
  import elt_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  log_t nxt,
  output log_t cur
);
  // sticky: only the power-on reset touches this storage
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cur <= '0;
    else        cur <= nxt;
  end
endmodule

// File: rtl/elt_readout.sv
module elt_readout #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         warm_rst_n,
  input  logic         rd_hit,
  input  logic [W-1:0] value,
  output logic [W-1:0] rdata
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           rdata <= '0;
    else if (!warm_rst_n) rdata <= '0;
    else if (rd_hit)      rdata <= value;
    else                  rdata <= '0;
  end
endmodule

// File: rtl/ecc_tid_logger.sv
module ecc_tid_logger
  import elt_pkg::*;
#(
  parameter logic [FUNC_W-1:0] MY_FUNC = '0,
  parameter logic [OFF_W-1:0]  MY_OFF  = 8'h80
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              retire_valid,
  input  logic              retire_sbe,
  input  logic [TID_W-1:0]  retire_tid,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [FUNC_W-1:0] cfg_func,
  input  logic [OFF_W-1:0]  cfg_offset,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata
);
  logic wr_hit, rd_hit, cap_evt, clr_evt;
  log_t log_cur, log_nxt;
  logic [REG_W-1:0] log_q;

  assign log_q = log_cur;

  elt_cfg_decode #(
    .FUNC_W(FUNC_W), .OFF_W(OFF_W), .MY_FUNC(MY_FUNC), .MY_OFF(MY_OFF)
  ) u_dec (
    .active(warm_rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_func(cfg_func), .cfg_offset(cfg_offset),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  elt_capture u_cap (
    .active(warm_rst_n), .retire_valid(retire_valid), .retire_sbe(retire_sbe),
    .retire_tid(retire_tid), .wr_hit(wr_hit), .wdata(cfg_wdata),
    .cur(log_cur), .cap_evt(cap_evt), .clr_evt(clr_evt), .nxt(log_nxt)
  );

  elt_log_store u_store (
    .clk(clk), .por_n(por_n), .nxt(log_nxt), .cur(log_cur)
  );

  elt_readout #(.W(REG_W)) u_rd (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .rd_hit(rd_hit), .value(log_q), .rdata(cfg_rdata)
  );
endmodule

// File: rtl/elt_checker.sv
module elt_checker
  import elt_pkg::*;
(
  input logic             clk,
  input logic             por_n,
  input logic             warm_rst_n,
  input logic [TID_W-1:0] retire_tid,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             wr_hit,
  input logic             rd_hit,
  input logic             cap_evt,
  input logic             clr_evt,
  input logic [REG_W-1:0] log_q
);
  // R3
  capture_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    cap_evt |=> (log_q[FLAG_BIT] && log_q[TID_W-1:0] == $past(retire_tid)));
  // R5
  hold_first_chk: assert property (@(posedge clk) disable iff (!por_n)
    (log_q[FLAG_BIT] && !clr_evt) |=> $stable(log_q[FLAG_BIT:0]));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    (clr_evt && !cap_evt) |=> (log_q[FLAG_BIT:0] == '0));
  // R7
  zero_write_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_hit && !cfg_wdata[FLAG_BIT] && !cap_evt) |=> $stable(log_q[FLAG_BIT:0]));
  // R9
  capture_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cap_evt && clr_evt) |=> log_q[FLAG_BIT]);
  // R10
  warm_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |=> ($stable(log_q) && cfg_rdata == '0));
  // R2
  idle_read_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rd_hit |=> (cfg_rdata == '0));
endmodule

bind ecc_tid_logger elt_checker u_chk (
  .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .retire_tid(retire_tid),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wr_hit(wr_hit), .rd_hit(rd_hit),
  .cap_evt(cap_evt), .clr_evt(clr_evt), .log_q(log_q)
);

// File: tb/ecc_tid_logger_test.sv
module ecc_tid_logger_test;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       warm_rst_n = 1'b1;
  logic       retire_valid = 1'b0;
  logic       retire_sbe = 1'b0;
  logic [5:0] retire_tid = '0;
  logic       cfg_wr = 1'b0;
  logic       cfg_rd = 1'b0;
  logic [2:0] cfg_func = '0;
  logic [7:0] cfg_offset = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  ecc_tid_logger uut (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .retire_valid(retire_valid), .retire_sbe(retire_sbe), .retire_tid(retire_tid),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_func(cfg_func), .cfg_offset(cfg_offset),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  // vector: {kind[1:0], tid[5:0], wdata[7:0], expected[7:0]}
  localparam logic [1:0] K_ERR = 2'd0, K_CLEAN = 2'd1, K_NOVALID = 2'd2, K_WRITE = 2'd3;
  localparam int NV = 10;
  localparam logic [23:0] VECS [NV] = '{
    {K_CLEAN,   6'h15, 8'h00, 8'h00},  // R4 clean retire ignored
    {K_ERR,     6'h2A, 8'h00, 8'h6A},  // R3 first error captured
    {K_ERR,     6'h11, 8'h00, 8'h6A},  // R5 second error dropped
    {K_WRITE,   6'h00, 8'h80, 8'hEA},  // R8 bit7 set, R7 flag kept
    {K_WRITE,   6'h00, 8'hBF, 8'hEA},  // R7 read-only bits ignored
    {K_WRITE,   6'h00, 8'hC0, 8'h80},  // R6 clear by writing one
    {K_ERR,     6'h05, 8'h00, 8'hC5},  // R3 re-armed, R8 bit7 no effect
    {K_WRITE,   6'h00, 8'h40, 8'h00},  // R6 clear, bit7 written back to 0
    {K_NOVALID, 6'h21, 8'h00, 8'h00},  // R4 flag without valid ignored
    {K_ERR,     6'h3F, 8'h00, 8'h7F}   // R3 all-ones identifier
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    retire_valid = 1'b0; retire_sbe = 1'b0; retire_tid = '0;
    cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_func = '0; cfg_offset = '0; cfg_wdata = '0;
  endtask

  task automatic do_read(input logic [2:0] f, input logic [7:0] off, output logic [7:0] v);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_func = f; cfg_offset = off;
    @(negedge clk);
    v = cfg_rdata;
    idle_inputs();
  endtask

  task automatic do_write(input logic [2:0] f, input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_func = f; cfg_offset = off; cfg_wdata = d;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_retire(input logic v, input logic s, input logic [5:0] t);
    @(negedge clk);
    retire_valid = v; retire_sbe = s; retire_tid = t;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    // R1 reset state
    check("R1 rdata after reset", cfg_rdata, 8'h00);
    do_read(3'd0, 8'h80, rv);
    check("R1 register after reset", rv, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      k = VECS[i][23:22];
      case (k)
        K_ERR:     do_retire(1'b1, 1'b1, VECS[i][21:16]);
        K_CLEAN:   do_retire(1'b1, 1'b0, VECS[i][21:16]);
        K_NOVALID: do_retire(1'b0, 1'b1, VECS[i][21:16]);
        default:   do_write(3'd0, 8'h80, VECS[i][15:8]);
      endcase
      do_read(3'd0, 8'h80, rv);
      check($sformatf("table vector %0d", i), rv, VECS[i][7:0]);
    end
    // register now 7Fh

    // R2 reads at other addresses return zero
    do_read(3'd1, 8'h80, rv);
    check("R2 other function reads zero", rv, 8'h00);
    do_read(3'd0, 8'h84, rv);
    check("R2 other offset reads zero", rv, 8'h00);
    @(negedge clk);
    check("R2 rdata back to zero without read", cfg_rdata, 8'h00);

    // R11 write elsewhere ignored
    do_write(3'd0, 8'h81, 8'hC0);
    do_write(3'd2, 8'h80, 8'hC0);
    do_read(3'd0, 8'h80, rv);
    check("R11 foreign writes ignored", rv, 8'h7F);

    // R9 simultaneous clear and capture: capture wins
    @(negedge clk);
    cfg_wr = 1'b1; cfg_func = 3'd0; cfg_offset = 8'h80; cfg_wdata = 8'h40;
    retire_valid = 1'b1; retire_sbe = 1'b1; retire_tid = 6'h0C;
    @(negedge clk);
    idle_inputs();
    do_read(3'd0, 8'h80, rv);
    check("R9 capture wins over clear", rv, 8'h4C);

    // R10 warm reset keeps register and blocks traffic
    do_write(3'd0, 8'h80, 8'h80);  // bit7 on -> CCh
    @(negedge clk);
    cfg_rd = 1'b1; cfg_func = 3'd0; cfg_offset = 8'h80;
    @(negedge clk);
    idle_inputs();
    check("R10 readback before warm reset", cfg_rdata, 8'hCC);
    warm_rst_n = 1'b0;
    cfg_wr = 1'b1; cfg_func = 3'd0; cfg_offset = 8'h80; cfg_wdata = 8'h40;
    retire_valid = 1'b1; retire_sbe = 1'b1; retire_tid = 6'h33;
    @(negedge clk);
    check("R10 rdata zero in warm reset", cfg_rdata, 8'h00);
    cfg_wr = 1'b0; cfg_rd = 1'b1;
    @(negedge clk);
    check("R10 read ignored in warm reset", cfg_rdata, 8'h00);
    idle_inputs();
    warm_rst_n = 1'b1;
    do_read(3'd0, 8'h80, rv);
    check("R10 register survives warm reset", rv, 8'hCC);

    // R1 power-on reset clears the sticky register
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    do_read(3'd0, 8'h80, rv);
    check("R1 power-on reset clears register", rv, 8'h00);

    finish_run();
  end
endmodule